// File: doc/BRIEF.md
# Two-Processor Shared Memory Arbiter and Cross-Interrupt Latch

Two processors, called main and sub, each have a small control register at I/O address 0x4016. A write to it latches three bits: a controller strobe, a cross-processor control bit and a graphics bank select. The control bit of each side drives the other side's active-low interrupt request. On the main side only, the same bit also decides which processor owns a 2 KiB shared RAM window decoded at 0x6000-0x7FFF. The external RAM array is connected to whichever side holds that window. The other side reads open bus there, and its writes there are dropped.

Ownership is a two-state machine, `OWN_SUB` and `OWN_MAIN`. The transition GRANT_MAIN (`OWN_SUB` to `OWN_MAIN`) happens when the main side writes the register with bit 1 set and the strap is low. The transition REVOKE (`OWN_MAIN` to `OWN_SUB`) happens when the main side writes bit 1 clear, or when the strap input is high. The strap models a board option that ties the main control bit low for good. A read of 0x4016 tells software which side it runs on. Every other read that the block does not decode returns that side's open-bus byte.

Top module: `dual_side_ctrl`

## Requirements
- R1: After reset, every latched bit on both sides is 0. Both strobes and both bank selects are 0, both interrupt outputs are low (asserted), and the sub side owns the RAM window.
- R2: A write to address 0x4016 latches data bit 0 onto that side's strobe output and data bit 2 onto its bank select output. Both outputs are visible one clock after the write.
- R3: The sub side's interrupt output equals the main side's latched bit 1, and the main side's interrupt output equals the sub side's latched bit 1. A value of 0 asserts the request.
- R4: When the main side's latched bit 1 is 1, the main side owns the window; when it is 0, the sub side owns it. The owner's accesses in 0x6000-0x7FFF reach the RAM at address bits 10:0, so the 2 KiB repeats through the 8 KiB window.
- R5: A write by the sub side to 0x4016 never changes ownership.
- R6: The non-owner's reads in the window return its open-bus byte, and its writes there do not reach the RAM.
- R7: A read of 0x4016 returns bit 7 = 0 on the main side and 1 on the sub side, with bits 6:0 = 0.
- R8: Each side keeps an open-bus byte. It is the data of that side's last write, or the data returned by its last read. Reads of any address other than 0x4016 and an owned window return it.
- R9: While the strap input is high, the main control bit is forced to 0. The sub interrupt is asserted at once, the sub side owns the window, and the stored main bit is 0 from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_lo | input | 1 | Ties the main control bit low |
| m_addr | input | 16 | Main bus address |
| m_wdata | input | 8 | Main write data |
| m_wr | input | 1 | Main write strobe |
| m_rd | input | 1 | Main read strobe |
| m_rdata | output | 8 | Main read data |
| m_strobe | output | 1 | Main controller strobe |
| m_gfx_bank | output | 1 | Main graphics bank select |
| m_irq_n | output | 1 | Interrupt request into main, active low |
| s_addr | input | 16 | Sub bus address |
| s_wdata | input | 8 | Sub write data |
| s_wr | input | 1 | Sub write strobe |
| s_rd | input | 1 | Sub read strobe |
| s_rdata | output | 8 | Sub read data |
| s_strobe | output | 1 | Sub controller strobe |
| s_gfx_bank | output | 1 | Sub graphics bank select |
| s_irq_n | output | 1 | Interrupt request into sub, active low |
| ram_addr | output | 11 | Shared RAM address |
| ram_wdata | output | 8 | Shared RAM write data |
| ram_wr | output | 1 | Shared RAM write enable |
| ram_rdata | input | 8 | Shared RAM read data (combinational) |

## Verification
The bench targets the following corner cases.

- **Sub side changes ownership.** It writes bit 1 while the main side owns the window. A design that let it steer ownership would hand the RAM away, and the main side's next read would return open bus.
- **Non-owner accesses.** Both sides hit the window in the same cycle. A design that routed the wrong side, or ignored ownership, would corrupt RAM contents that the owner reads back later.
- **Open bus and identity reads.** It mixes reads of open bus, the identity byte and mirrored window addresses. A wrong bit 7, a missing address mirror or a stale open-bus byte each shows up as a data mismatch.
- **Strap.** It pulses the strap during traffic. A design whose strap failed to override the main bit would release the sub interrupt, or keep the main side as owner.

// File: rtl/dual_pkg.sv
package dual_pkg;
    localparam int unsigned ADDR_W   = 16;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned RAM_AW   = 11;
    localparam logic [15:0] CTL_ADDR = 16'h4016;
    localparam logic [2:0]  WIN_TAG  = 3'b011;

    typedef enum logic {
        OWN_SUB  = 1'b0,
        OWN_MAIN = 1'b1
    } owner_t;
endpackage

// File: rtl/owner_fsm.sv
module owner_fsm
    import dual_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strap,
    input  logic ctl_wr,
    input  logic ctl_bit,
    output logic state_main,
    output logic main_owns
);
    owner_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OWN_SUB;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OWN_SUB:  if (!strap && ctl_wr && ctl_bit)      state_d = OWN_MAIN;
            OWN_MAIN: if (strap || (ctl_wr && !ctl_bit))    state_d = OWN_SUB;
            default:  state_d = OWN_SUB;
        endcase
    end

    always_comb begin
        state_main = (state_q == OWN_MAIN);
        main_owns  = state_main && !strap;
    end

    // R9
    strap_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strap |=> state_q == OWN_SUB);
    // R4
    grant_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !strap) |=> state_main == $past(ctl_bit));
endmodule

// File: rtl/side_port.sv
module side_port
    import dual_pkg::*;
#(
    parameter bit IS_SUB = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic              re,
    input  logic              owns_ram,
    input  logic              force_clr,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] rdata,
    output logic              strobe,
    output logic              gfx_bank,
    output logic              xbit,
    output logic              win_hit,
    output logic              ctl_wr
);
    logic              ctl_hit;
    logic [2:0]        lat_q;
    logic [DATA_W-1:0] ob_q;

    always_comb begin
        win_hit = (addr[ADDR_W-1 -: 3] == WIN_TAG);
        ctl_hit = (addr == CTL_ADDR);
        ctl_wr  = we && ctl_hit;
        if (win_hit && owns_ram) rdata = ram_rdata;
        else if (ctl_hit)        rdata = {IS_SUB, {(DATA_W-1){1'b0}}};
        else                     rdata = ob_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
            ob_q  <= '0;
        end else begin
            if (ctl_wr) lat_q <= wdata[2:0];
            if (force_clr) lat_q[1] <= 1'b0;
            if (we)      ob_q <= wdata;
            else if (re) ob_q <= rdata;
        end
    end

    assign strobe   = lat_q[0];
    assign xbit     = lat_q[1];
    assign gfx_bank = lat_q[2];

    // R8
    obus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we || re) |=> $stable(ob_q));
    // R2
    bank_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> gfx_bank == $past(wdata[2]));
    // R7
    ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (re && ctl_hit) |-> (rdata[DATA_W-1] == IS_SUB));
endmodule

// File: rtl/dual_side_ctrl.sv
module dual_side_ctrl
    import dual_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_lo,
    input  logic [15:0]       m_addr,
    input  logic [7:0]        m_wdata,
    input  logic              m_wr,
    input  logic              m_rd,
    output logic [7:0]        m_rdata,
    output logic              m_strobe,
    output logic              m_gfx_bank,
    output logic              m_irq_n,
    input  logic [15:0]       s_addr,
    input  logic [7:0]        s_wdata,
    input  logic              s_wr,
    input  logic              s_rd,
    output logic [7:0]        s_rdata,
    output logic              s_strobe,
    output logic              s_gfx_bank,
    output logic              s_irq_n,
    output logic [10:0]       ram_addr,
    output logic [7:0]        ram_wdata,
    output logic              ram_wr,
    input  logic [7:0]        ram_rdata
);
    logic main_owns, state_main;
    logic m_x, s_x, m_win, s_win, m_ctl_wr, s_ctl_wr;

    owner_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .strap(strap_lo),
        .ctl_wr(m_ctl_wr), .ctl_bit(m_wdata[1]),
        .state_main(state_main), .main_owns(main_owns)
    );

    side_port #(.IS_SUB(1'b0)) u_main (
        .clk(clk), .rst_n(rst_n), .addr(m_addr), .wdata(m_wdata),
        .we(m_wr), .re(m_rd), .owns_ram(main_owns), .force_clr(strap_lo),
        .ram_rdata(ram_rdata), .rdata(m_rdata), .strobe(m_strobe),
        .gfx_bank(m_gfx_bank), .xbit(m_x), .win_hit(m_win), .ctl_wr(m_ctl_wr)
    );

    side_port #(.IS_SUB(1'b1)) u_sub (
        .clk(clk), .rst_n(rst_n), .addr(s_addr), .wdata(s_wdata),
        .we(s_wr), .re(s_rd), .owns_ram(!main_owns), .force_clr(1'b0),
        .ram_rdata(ram_rdata), .rdata(s_rdata), .strobe(s_strobe),
        .gfx_bank(s_gfx_bank), .xbit(s_x), .win_hit(s_win), .ctl_wr(s_ctl_wr)
    );

    always_comb begin
        if (main_owns) begin
            ram_addr  = m_addr[RAM_AW-1:0];
            ram_wdata = m_wdata;
            ram_wr    = m_wr && m_win;
        end else begin
            ram_addr  = s_addr[RAM_AW-1:0];
            ram_wdata = s_wdata;
            ram_wr    = s_wr && s_win;
        end
        s_irq_n = m_x && !strap_lo;
        m_irq_n = s_x;
    end

    // R4
    owner_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_main == m_x);
    // R5
    sub_no_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ctl_wr && !m_ctl_wr && !strap_lo) |=> $stable(state_main));
    // R6
    sub_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (main_owns && s_wr && s_win && !(m_wr && m_win)) |-> !ram_wr);
    // R9
    strap_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strap_lo |-> !s_irq_n);
endmodule

// File: tb/sim_dual_side_ctrl.sv
`timescale 1ns/1ps
module sim_dual_side_ctrl;
    logic clk = 1'b0, rst_n = 1'b0, strap_lo = 1'b0;
    logic [15:0] m_addr = '0, s_addr = '0;
    logic [7:0]  m_wdata = '0, s_wdata = '0, m_rdata, s_rdata;
    logic m_wr = 0, m_rd = 0, s_wr = 0, s_rd = 0;
    logic m_strobe, m_gfx_bank, m_irq_n, s_strobe, s_gfx_bank, s_irq_n;
    logic [10:0] ram_addr;
    logic [7:0]  ram_wdata, ram_rdata;
    logic ram_wr;

    logic [7:0] mem [2048];
    logic [7:0] ref_mem [2048];
    int checks = 0, fails = 0;
    bit done = 0;
    // model state
    logic mstb = 0, mgfx = 0, mx = 0, sstb = 0, sgfx = 0, sx = 0;
    logic [7:0] obm = 0, obs = 0, last_m = 0, last_s = 0;

    always #5 clk = ~clk;

    dual_side_ctrl u0 (.*);

    assign ram_rdata = mem[ram_addr];
    always @(posedge clk) if (ram_wr) mem[ram_addr] <= ram_wdata;

    function automatic bit in_win(logic [15:0] a);
        return a[15:13] == 3'b011;
    endfunction

    function automatic logic [7:0] exp_rd(bit sub, logic [15:0] a, bit own, logic [7:0] ob);
        if (in_win(a) && own) return ref_mem[a[10:0]];
        if (a == 16'h4016)    return {sub, 7'b0};
        return ob;
    endfunction

    function automatic string rd_tag(logic [15:0] a, bit own);
        if (in_win(a)) return own ? "R4" : "R6";
        if (a == 16'h4016) return "R7";
        return "R8";
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic cyc(bit mw, bit mr, logic [15:0] ma, logic [7:0] mwd,
                       bit sw, bit sr, logic [15:0] sa, logic [7:0] swd, bit tie);
        bit mown;
        logic [7:0] em, es;
        @(negedge clk);
        m_wr = mw; m_rd = mr; m_addr = ma; m_wdata = mwd;
        s_wr = sw; s_rd = sr; s_addr = sa; s_wdata = swd; strap_lo = tie;
        #1;
        mown = mx && !tie;
        em = exp_rd(1'b0, ma, mown, obm);
        es = exp_rd(1'b1, sa, !mown, obs);
        if (mr) begin chk(rd_tag(ma, mown), m_rdata, em); last_m = m_rdata; end
        if (sr) begin chk(rd_tag(sa, !mown), s_rdata, es); last_s = s_rdata; end
        @(posedge clk); #1;
        if (mown && mw && in_win(ma))   ref_mem[ma[10:0]] = mwd;
        if (!mown && sw && in_win(sa))  ref_mem[sa[10:0]] = swd;
        if (mw) obm = mwd; else if (mr) obm = em;
        if (sw) obs = swd; else if (sr) obs = es;
        if (mw && ma == 16'h4016) begin mstb = mwd[0]; mx = mwd[1]; mgfx = mwd[2]; end
        if (tie) mx = 0;
        if (sw && sa == 16'h4016) begin sstb = swd[0]; sx = swd[1]; sgfx = swd[2]; end
        chk("R2", {6'b0, m_gfx_bank, m_strobe}, {6'b0, mgfx, mstb});
        chk("R2", {6'b0, s_gfx_bank, s_strobe}, {6'b0, sgfx, sstb});
        chk(tie ? "R9" : "R3", {7'b0, s_irq_n}, {7'b0, mx && !tie});
        chk("R3", {7'b0, m_irq_n}, {7'b0, sx});
    endtask

    task automatic idle();
        cyc(0, 0, 16'h0, 8'h0, 0, 0, 16'h0, 8'h0, 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 2048; i++) begin mem[i] = '0; ref_mem[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        // R1 reset state
        chk("R1", {4'b0, m_strobe, m_gfx_bank, s_strobe, s_gfx_bank}, 8'h00);
        chk("R1", {6'b0, m_irq_n, s_irq_n}, 8'h00);
        cyc(0, 0, 0, 0, 1, 0, 16'h6010, 8'hA5, 0);       // sub owns after reset
        cyc(0, 0, 0, 0, 0, 1, 16'h6010, 0, 0);
        chk("R1", last_s, 8'hA5);
        // R2 strobe then bank
        cyc(1, 0, 16'h4016, 8'h05, 0, 0, 0, 0, 0);
        cyc(1, 0, 16'h4016, 8'h00, 0, 0, 0, 0, 0);
        // R4 grant to main, write mirror and read back
        cyc(1, 0, 16'h4016, 8'h02, 0, 0, 0, 0, 0);
        cyc(1, 0, 16'h6005, 8'h3C, 1, 0, 16'h6005, 8'hFF, 0); // R6 sub write dropped
        cyc(1, 0, 16'h4017, 8'h77, 0, 1, 16'h6005, 0, 0);     // R6 sub sees open bus
        chk("R6", last_s, 8'hFF);
        cyc(0, 1, 16'h7805, 0, 0, 0, 0, 0, 0);
        chk("R4", last_m, 8'h3C);
        // R5 sub toggles its bit, ownership stays
        cyc(0, 0, 0, 0, 1, 0, 16'h4016, 8'h00, 0);
        cyc(0, 1, 16'h6005, 0, 1, 0, 16'h4016, 8'h02, 0);
        chk("R5", last_m, 8'h3C);
        // R7 identity
        cyc(0, 1, 16'h4016, 0, 0, 1, 16'h4016, 0, 0);
        chk("R7", last_m, 8'h00);
        chk("R7", last_s, 8'h80);
        // R8 open bus after write
        cyc(1, 0, 16'h2000, 8'h5A, 0, 0, 0, 0, 0);
        cyc(0, 1, 16'h0123, 0, 0, 0, 0, 0, 0);
        chk("R8", last_m, 8'h5A);
        // R9 strap
        cyc(0, 0, 0, 0, 0, 1, 16'h6005, 0, 1);
        chk("R9", last_s, 8'h3C);
        cyc(1, 0, 16'h4016, 8'h02, 0, 0, 0, 0, 1);
        idle();
        // random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] a [2];
            int op [2];
            for (int k = 0; k < 2; k++) begin
                op[k] = $urandom % 3;
                case ($urandom % 4)
                    0: a[k] = 16'h4016;
                    1, 2: a[k] = 16'h6000 | 16'($urandom % 16'h2000);
                    default: a[k] = 16'($urandom % 16'h4000);
                endcase
            end
            cyc(op[0] == 2, op[0] == 1, a[0], 8'($urandom),
                op[1] == 2, op[1] == 1, a[1], 8'($urandom),
                ($urandom % 16) == 0);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule